// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the device-side digital half of a three-wire serial converter link. A host drives an active-low select line and a data clock. The block answers on a single data line that can be released to high impedance. When select falls, the block captures a parallel conversion value. On each falling data-clock edge after that it moves one step through a fixed frame. The first edge gives no output. The second edge turns the driver on with a low null bit. The next edges give the word most significant bit first, then the word again least significant bit first, with the last bit of the first pass serving as the first bit of the second. After that the line carries zeros for as long as clocks keep coming.

A power-down status output shows when the converter would have its comparator and bias turned off. That is the case while the block is deselected, and also once the final conversion bit has gone out, even if select stays low. The select and data-clock inputs are asynchronous. They are synchronised to a faster system clock, and the data clock must run at no more than a quarter of the system clock rate. The block can stand in for a real converter in a system model, or act as a target for checking a host controller.

Top module: `sadc_out_seq`

## Requirements
- R1: After a synchronous active-low reset, with select high, the output enable is 0 and the power-down status is 1.
- R2: While select is high, falling data-clock edges do not enable the output, and the power-down status stays 1.
- R3: After select falls, the output stays disabled through the first falling data-clock edge. The second falling edge enables it with a null bit of value 0.
- R4: Falling edges 3 to 14 after select falls drive the captured value most significant bit first: edge 3 gives bit 11 and edge 14 gives bit 0.
- R5: Falling edges 15 to 25 drive bit 1 up to bit 11, so the word goes out again least significant bit first, with bit 0 shared with the first pass.
- R6: From falling edge 26 onward, every further edge drives 0 for as long as select stays low.
- R7: The power-down status is 0 from the moment select falls until falling edge 14. From edge 14 on it is 1, even while select stays low.
- R8: A rising select removes the output enable at once, without waiting for a system clock edge. The next frame starts again with the null bit.
- R9: The parallel value is captured when select falls. Changes to the parallel input during the frame have no effect on the bits driven.
- R10: Rising data-clock edges do not advance the sequence. The output holds its last value until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the data clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host (asynchronous) |
| sclk | input | 1 | Data clock from the host (asynchronous) |
| sample_val | input | 12 | Parallel conversion value, captured when select falls |
| sdo | output | 1 | Serial data, high impedance when disabled |
| sdo_oe | output | 1 | Enable of the serial data driver |
| pwr_down | output | 1 | Comparator and bias powered-down status |

## Verification
Each data-clock edge passes through two synchroniser stages and one edge-detect register. The sequence counter then updates on the third system-clock edge after the data clock moves. The data bit, the enable and the power-down status are decoded from that counter without a further register, so all three are valid after three system clocks. The bench holds each data-clock level for four system clocks and samples on the falling system-clock edge at the end of each half period. This places every check one clock after the result is due, and it also confirms that the output holds across the rising half (R10). A rising select is checked one time step after it is driven, with no clock in between, because the enable is gated directly by the raw select. The power-down status and the restart of the frame are checked four clocks later.

// File: rtl/sadc_pkg.sv
// Package: shared types and constants for the serial ADC output sequencer.
// Assumes: one frame is the null slot, then the word MSB first, then the word LSB first, then zeros.
package sadc_pkg;

    // Where the sequence counter stands within a frame
    typedef enum logic [2:0] {
        PH_WAIT = 3'd0,   // before the driver is enabled
        PH_NULL = 3'd1,   // null bit slot
        PH_MSB  = 3'd2,   // word, most significant bit first
        PH_LSB  = 3'd3,   // word repeated, least significant bit first
        PH_ZERO = 3'd4    // trailing zeros
    } seq_phase_t;

    // Falling data-clock edge count at which the null bit is driven
    localparam int NULL_SLOT = 2;

endpackage

// File: rtl/sadc_sync.sv
// Module: multi-bit level synchroniser for asynchronous host lines.
// Assumes: each bit is an independent slow level; STAGES >= 2; INIT is the idle level after reset.
module sadc_sync #(
    parameter int             N      = 2,
    parameter int             STAGES = 2,
    parameter logic [N-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stg [STAGES];

    // Shift the raw levels through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sadc_frame_ctl.sv
// Module: frame sequencer. Counts falling data-clock edges while selected,
// captures the parallel value when select falls, decodes the frame phase and power-down status.
// Assumes: inputs are already synchronised; the count saturates at the first zero slot.
module sadc_frame_ctl
    import sadc_pkg::*;
#(
    parameter int W  = 12,
    parameter int CW = $clog2(2*W + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_lvl,     // synchronised select, high = deselected
    input  logic          sclk_lvl,    // synchronised data clock
    input  logic [W-1:0]  par_in,
    output logic [CW-1:0] cnt,
    output logic [W-1:0]  held,
    output seq_phase_t    phase,
    output logic          pwr_down
);

    localparam logic [CW-1:0] NULL_AT = CW'(NULL_SLOT);
    localparam logic [CW-1:0] MSB_END = CW'(NULL_SLOT + W);      // slot of bit 0
    localparam logic [CW-1:0] LSB_END = CW'(NULL_SLOT + 2*W - 1); // slot of the repeated top bit
    localparam logic [CW-1:0] ZERO_AT = CW'(NULL_SLOT + 2*W);

    logic sel_q;
    logic sclk_q;
    logic sel_fall;
    logic sclk_fall;

    assign sel_fall  = sel_q & ~sel_lvl;
    assign sclk_fall = sclk_q & ~sclk_lvl;

    // Remember the previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            sel_q  <= sel_lvl;
            sclk_q <= sclk_lvl;
        end
    end

    // Count falling data-clock edges within a frame; clear while deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sel_lvl) begin
            cnt <= '0;
        end else if (sclk_fall && (cnt != ZERO_AT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Capture the conversion value at the start of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (sel_fall) begin
            held <= par_in;
        end
    end

    // Decode the frame phase from the edge count
    always_comb begin
        if (cnt < NULL_AT)
            phase = PH_WAIT;
        else if (cnt == NULL_AT)
            phase = PH_NULL;
        else if (cnt <= MSB_END)
            phase = PH_MSB;
        else if (cnt <= LSB_END)
            phase = PH_LSB;
        else
            phase = PH_ZERO;
    end

    // Power down when deselected or once the last conversion bit is out
    assign pwr_down = sel_lvl | (cnt >= MSB_END);

endmodule

// File: rtl/sadc_bit_mux.sv
// Module: selects the serial bit for the current slot from the captured word.
// Assumes: cnt is the falling-edge count from the frame sequencer; the null and zero slots give 0.
module sadc_bit_mux
    import sadc_pkg::*;
#(
    parameter int W  = 12,
    parameter int CW = $clog2(2*W + 3)
) (
    input  logic [CW-1:0] cnt,
    input  seq_phase_t    phase,
    input  logic [W-1:0]  word,
    output logic          bit_o
);

    // Map the slot number to a word bit in either direction
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (phase == PH_MSB && cnt == CW'(NULL_SLOT + W - i))
                bit_o = word[i];
            if (phase == PH_LSB && cnt == CW'(NULL_SLOT + W + i))
                bit_o = word[i];
        end
    end

endmodule

// File: rtl/sadc_out_seq.sv
// Module: top of the serial ADC output sequencer. Synchronises the host lines,
// runs the frame sequencer and drives the tri-state serial output.
// Assumes: the data clock runs at no more than a quarter of clk; a rising select
// releases the output without waiting for a clock edge.
module sadc_out_seq
    import sadc_pkg::*;
#(
    parameter int VAL_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sclk,
    input  logic [VAL_W-1:0] sample_val,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             pwr_down
);

    localparam int CW = $clog2(2*VAL_W + 3);

    logic [1:0]       lines_sync;
    logic [CW-1:0]    cnt;
    logic [VAL_W-1:0] held;
    seq_phase_t       phase;
    logic             data_bit;

    sadc_sync #(
        .N      (2),
        .STAGES (SYNC_STAGES),
        .INIT   (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sclk}),
        .q     (lines_sync)
    );

    sadc_frame_ctl #(
        .W  (VAL_W),
        .CW (CW)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_lvl  (lines_sync[1]),
        .sclk_lvl (lines_sync[0]),
        .par_in   (sample_val),
        .cnt      (cnt),
        .held     (held),
        .phase    (phase),
        .pwr_down (pwr_down)
    );

    sadc_bit_mux #(
        .W  (VAL_W),
        .CW (CW)
    ) u_mux (
        .cnt   (cnt),
        .phase (phase),
        .word  (held),
        .bit_o (data_bit)
    );

    // Enable the driver from the null slot on; the raw select cuts it at once
    assign sdo_oe = (phase != PH_WAIT) & ~lines_sync[1] & ~sel_n;

    // Tri-state output buffer
    assign sdo = sdo_oe ? data_bit : 1'bz;

endmodule

// File: rtl/sadc_out_seq_chk.sv
// Module: protocol checker for the serial ADC output sequencer, bound to the top.
// Assumes: observes ports only; reset is synchronous and active low.
module sadc_out_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic sdo,
    input logic sdo_oe,
    input logic pwr_down
);

    // R8: a rising select leaves the driver off in that same cycle
    a_r8_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> !sdo_oe);

    // R3: the first driven bit of a frame is the null bit
    a_r3_null_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (sdo == 1'b0));

    // R7: power comes up before the driver is enabled
    a_r7_power_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> !sdo_oe);

    // R7: power comes up only after the host has selected the block
    a_r7_power_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> $past(!sel_n));

endmodule

bind sadc_out_seq sadc_out_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .pwr_down (pwr_down)
);

// File: tb/sadc_out_seq_test.sv
// Bench: drives select and data-clock frames with directed and random words and
// frame lengths, and compares the outputs with values from bench functions.
module sadc_out_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int HALF       = 4;   // system clocks per data-clock half period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] sample_val = '0;
    logic         sdo;
    logic         sdo_oe;
    logic         pwr_down;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_out_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .sclk       (sclk),
        .sample_val (sample_val),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .pwr_down   (pwr_down)
    );

    // Expected enable after k falling edges
    function automatic logic exp_oe(int k);
        return k >= 2;
    endfunction

    // Expected data bit after k falling edges for word v
    function automatic logic exp_bit(int k, logic [W-1:0] v);
        if (k >= 3 && k <= W + 2)       return v[W + 2 - k];
        if (k >= W + 3 && k <= 2*W + 1) return v[k - W - 2];
        return 1'b0;
    endfunction

    // Expected power-down status after k falling edges while selected
    function automatic logic exp_pd(int k);
        return k >= W + 2;
    endfunction

    // Requirement that the slot after k edges belongs to
    function automatic string slot_req(int k);
        if (k <= 2)     return "R3";
        if (k <= W + 2) return "R4";
        if (k <= 2*W+1) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare all outputs with the state after k falling edges
    task automatic check_slot(string req, int k, logic [W-1:0] v);
        chk(req, $sformatf("oe k=%0d", k), sdo_oe, exp_oe(k));
        if (exp_oe(k))
            chk(req, $sformatf("sdo k=%0d", k), sdo, exp_bit(k, v));
        chk("R7", $sformatf("pwr_down k=%0d", k), pwr_down, exp_pd(k));
    endtask

    // One frame: select, nclk data-clock pulses, deselect
    task automatic run_frame(logic [W-1:0] v, int nclk, bit scramble);
        sample_val = v;
        sel_n = 1'b0;
        wait_clks(HALF);
        check_slot("R3", 0, v);
        if (scramble) sample_val = ~v ^ W'($urandom);   // R9: ignored mid-frame
        for (int k = 1; k <= nclk; k++) begin
            sclk = 1'b1;
            wait_clks(HALF);
            check_slot("R10", k - 1, v);                 // rising edge must not advance
            sclk = 1'b0;
            wait_clks(HALF);
            check_slot(scramble ? "R9" : slot_req(k), k, v);
        end
        sel_n = 1'b1;
        #1;
        chk("R8", "oe right after deselect", sdo_oe, 1'b0);
        wait_clks(HALF);
        chk("R8", "oe after deselect", sdo_oe, 1'b0);
        chk("R2", "pwr_down after deselect", pwr_down, 1'b1);
    endtask

    // Main sequence
    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        chk("R1", "oe after reset", sdo_oe, 1'b0);
        chk("R1", "pwr_down after reset", pwr_down, 1'b1);

        // R2: clocks while deselected do nothing
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; wait_clks(HALF);
            sclk = 1'b0; wait_clks(HALF);
            chk("R2", "oe while deselected", sdo_oe, 1'b0);
            chk("R2", "pwr_down while deselected", pwr_down, 1'b1);
        end
        wait_clks(HALF);

        // Directed corner cases
        run_frame(12'hFFF, 30, 1'b0);
        run_frame(12'h000, 30, 1'b0);
        run_frame(12'hA5C, 30, 1'b1);
        run_frame(12'h801, 6, 1'b0);   // truncated, R8: next frame restarts
        run_frame(12'h3C7, 27, 1'b0);
        run_frame(12'h001, 1, 1'b0);

        // Random frames from a fixed seed
        void'($urandom(32'h5AD0_1286));
        for (int f = 0; f < 10; f++) begin
            run_frame(W'($urandom), 1 + int'($urandom % 32), bit'($urandom % 2));
            wait_clks(int'($urandom % 5));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule